// File: doc/BRIEF.md
# Real-Time-Clock Prescaler and Rate Selector

This block sits between a 32.768 kHz timebase and the rest of a real-time clock. It receives the timebase as a one-cycle enable on the system clock and counts it in a 15-stage binary prescaler. A three-bit oscillator-control field decides whether the prescaler runs, is held cleared, or is stopped. A four-bit rate code picks one prescaler stage. That stage drives both a gated square-wave output and a one-cycle periodic-event strobe.

The top stage of the prescaler produces a once-per-second update strobe for the calendar logic. The first update comes half a second after the prescaler is released. An update-in-progress status bit rises a fixed number of timebase periods before each update strobe, so that software knows when a transfer is about to happen. A freeze input blocks the transfer and drops the status bit. The prescaler keeps counting while frozen.

Top module: `rtcdiv_top`

## Requirements
- R1: After a synchronous reset, `sqw`, `periodic_stb`, `update_stb` and `uip` are all 0, and the prescaler count is zero.
- R2: The prescaler counts only while `osc_ctl` equals 3'b010. With `osc_ctl[2:1]` = 2'b11 it is held cleared. Any other pattern stops it and also clears it. While it is not counting, all four outputs are 0, and a later release starts counting from zero.
- R3: `periodic_stb` is a one-cycle pulse in the cycle after each enable tick on which the selected stage goes from 0 to 1. The pulse period is twice the stage's half-period.
- R4: Rate code mapping, with the half-period counted in enable ticks as 16384 divided by the frequency: 0 selects nothing, 1 selects 256 Hz, 2 selects 128 Hz, and codes 3 to 15 select 8192 Hz >> (code - 3), running down to 2 Hz.
- R5: `sqw` equals the level of the selected stage when `sqw_en` is 1. It is held 0 when `sqw_en` is 0 or the rate code is 0.
- R6: `update_stb` pulses for one cycle when the prescaler count reaches 16384. That happens first 16384 ticks after release, and then every 32768 ticks.
- R7: `uip` rises on the tick that brings the count to 16376, which is 8 ticks before the update. It stays high until the update strobe. An update strobe is only issued while `uip` is high.
- R8: While `freeze` is 1, `uip` is cleared and no update strobe is issued. The prescaler keeps counting, and `uip` cannot rise again until the next warning point.
- R9: In a cycle without an enable tick, the prescaler count and all stage levels hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| osc_ctl | input | 3 | Oscillator/prescaler control field |
| rate_sel | input | 4 | Stage select for square wave and periodic event |
| sqw_en | input | 1 | Square-wave output enable |
| freeze | input | 1 | Blocks update transfers and clears `uip` |
| sqw | output | 1 | Gated square wave |
| periodic_stb | output | 1 | One-cycle periodic event strobe |
| update_stb | output | 1 | One-cycle once-per-second update strobe |
| uip | output | 1 | Update-in-progress status |

## Verification
The hardest situation to reach is a freeze that arrives inside the eight-tick warning window. In that case `uip` is already high and the update must still be cancelled. The bench drives the enable on every cycle and follows its own model of the prescaler count. It raises `freeze` for one cycle when the model count reads 16379, and in a separate pass it holds `freeze` across a whole update point. A behavioural model compares all four outputs on every clock, while the stimulus sweeps all sixteen rate codes, adds random gaps in the enable, and stops and restarts the prescaler.

// File: rtl/rtcdiv_pkg.sv
package rtcdiv_pkg;

    localparam int DIV_STAGES = 15;
    localparam int RATE_W     = 4;
    localparam int OSC_W      = 3;
    localparam int IDX_W      = $clog2(DIV_STAGES);
    localparam int WARN_TICKS = 8;

    localparam logic [OSC_W-1:0] OSC_RUN = 3'b010;

    typedef enum logic [1:0] {
        CHAIN_STOP,
        CHAIN_HOLD,
        CHAIN_RUN
    } chain_mode_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } tap_sel_t;

    function automatic chain_mode_e decode_osc(input logic [OSC_W-1:0] osc);
        if (osc == OSC_RUN)
            return CHAIN_RUN;
        else if (osc[2:1] == 2'b11)
            return CHAIN_HOLD;
        else
            return CHAIN_STOP;
    endfunction

    // Stage k toggles at 16384 >> k Hz; codes 1 and 2 reuse stages 6 and 7.
    function automatic tap_sel_t pick_tap(input logic [RATE_W-1:0] code);
        tap_sel_t t;
        t.valid = 1'b1;
        case (code)
            4'd0:    begin t.valid = 1'b0; t.idx = '0; end
            4'd1:    t.idx = IDX_W'(6);
            4'd2:    t.idx = IDX_W'(7);
            default: t.idx = IDX_W'(code - 4'd2);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/rtcdiv_chain.sv
module rtcdiv_chain
    import rtcdiv_pkg::*;
#(
    parameter int DIV_W = DIV_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [OSC_W-1:0] osc_ctl,
    output logic [DIV_W-1:0] nxt_o,
    output logic [DIV_W-1:0] rise_o,
    output logic             run_o,
    output logic             step_o
);

    chain_mode_e      mode;
    logic [DIV_W-1:0] cnt_q;

    always_comb begin
        mode   = decode_osc(osc_ctl);
        run_o  = (mode == CHAIN_RUN);
        step_o = run_o & tick_en;
        if (!run_o)
            nxt_o = '0;
        else if (step_o)
            nxt_o = cnt_q + DIV_W'(1);
        else
            nxt_o = cnt_q;
        rise_o = ~cnt_q & nxt_o & {DIV_W{step_o}};
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= nxt_o;
    end

    // R9: no enable tick, no movement
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == CHAIN_RUN && !tick_en) |=> $stable(cnt_q));

    // R2: a non-running pattern leaves the chain at zero
    p_cleared_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (mode != CHAIN_RUN) |=> (cnt_q == '0));

endmodule

// File: rtl/rtcdiv_tap.sv
module rtcdiv_tap
    import rtcdiv_pkg::*;
#(
    parameter int DIV_W = DIV_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  nxt_i,
    input  logic [DIV_W-1:0]  rise_i,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sqw_en,
    output logic              sqw_o,
    output logic              pstb_o
);

    tap_sel_t sel;
    logic     tap_lvl;
    logic     tap_rise;

    always_comb begin
        sel      = pick_tap(rate_sel);
        tap_lvl  = sel.valid & nxt_i[sel.idx];
        tap_rise = sel.valid & rise_i[sel.idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sqw_o  <= 1'b0;
            pstb_o <= 1'b0;
        end else begin
            sqw_o  <= sqw_en & tap_lvl;
            pstb_o <= tap_rise;
        end
    end

    // R4: code zero silences both outputs
    p_none_code_r4: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == '0) |=> (!sqw_o && !pstb_o));

    // R5: disabled square wave is low
    p_sqw_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !sqw_en |=> !sqw_o);

    // R3: periodic strobe never lasts two cycles
    p_pstb_single_r3: assert property (@(posedge clk) disable iff (rst)
        pstb_o |=> !pstb_o);

endmodule

// File: rtl/rtcdiv_update.sv
module rtcdiv_update
    import rtcdiv_pkg::*;
#(
    parameter int DIV_W    = DIV_STAGES,
    parameter int UIP_LEAD = WARN_TICKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             step_i,
    input  logic [DIV_W-1:0] nxt_i,
    input  logic             top_rise_i,
    input  logic             freeze,
    output logic             uip_o,
    output logic             ustb_o
);

    localparam int               WARN_AT_I = (1 << (DIV_W - 1)) - UIP_LEAD;
    localparam logic [DIV_W-1:0] WARN_AT   = WARN_AT_I[DIV_W-1:0];

    logic ustb_d;
    logic uip_d;

    always_comb begin
        ustb_d = top_rise_i & uip_o & ~freeze;
        if (!run_i || freeze)
            uip_d = 1'b0;
        else if (step_i && nxt_i == WARN_AT)
            uip_d = 1'b1;
        else if (ustb_d)
            uip_d = 1'b0;
        else
            uip_d = uip_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uip_o  <= 1'b0;
            ustb_o <= 1'b0;
        end else begin
            uip_o  <= uip_d;
            ustb_o <= ustb_d;
        end
    end

    // R7: each update is announced by the status bit
    p_upd_after_uip_r7: assert property (@(posedge clk) disable iff (rst)
        ustb_o |-> $past(uip_o));

    // R8: freeze drops the status and blocks the transfer
    p_freeze_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        freeze |=> (!uip_o && !ustb_o));

    // R6: update strobe is a single cycle
    p_ustb_single_r6: assert property (@(posedge clk) disable iff (rst)
        ustb_o |=> !ustb_o);

endmodule

// File: rtl/rtcdiv_top.sv
module rtcdiv_top
    import rtcdiv_pkg::*;
#(
    parameter int DIV_W    = DIV_STAGES,
    parameter int UIP_LEAD = WARN_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [OSC_W-1:0]  osc_ctl,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sqw_en,
    input  logic              freeze,
    output logic              sqw,
    output logic              periodic_stb,
    output logic              update_stb,
    output logic              uip
);

    logic [DIV_W-1:0] nxt;
    logic [DIV_W-1:0] rise;
    logic             run;
    logic             step;

    rtcdiv_chain #(.DIV_W(DIV_W)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .osc_ctl (osc_ctl),
        .nxt_o   (nxt),
        .rise_o  (rise),
        .run_o   (run),
        .step_o  (step)
    );

    rtcdiv_tap #(.DIV_W(DIV_W)) u_tap (
        .clk      (clk),
        .rst      (rst),
        .nxt_i    (nxt),
        .rise_i   (rise),
        .rate_sel (rate_sel),
        .sqw_en   (sqw_en),
        .sqw_o    (sqw),
        .pstb_o   (periodic_stb)
    );

    rtcdiv_update #(.DIV_W(DIV_W), .UIP_LEAD(UIP_LEAD)) u_update (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run),
        .step_i     (step),
        .nxt_i      (nxt),
        .top_rise_i (rise[DIV_W-1]),
        .freeze     (freeze),
        .uip_o      (uip),
        .ustb_o     (update_stb)
    );

    // R2: a stopped or held prescaler keeps every output quiet
    p_stopped_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (osc_ctl != OSC_RUN) |=> (!sqw && !periodic_stb && !update_stb && !uip));

    // R1: outputs are zero in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sqw && !periodic_stb && !update_stb && !uip));

endmodule

// File: tb/tb_rtcdiv_top.sv
module tb_rtcdiv_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [2:0] osc_ctl = 3'b000;
    logic [3:0] rate_sel = 4'd0;
    logic       sqw_en = 1'b0;
    logic       freeze = 1'b0;
    logic       sqw, periodic_stb, update_stb, uip;

    int vectors = 0;
    int miscompares = 0;
    int cycle = 0;
    bit started = 0;
    bit done = 0;
    string phase_tag = "";

    // behavioural reference state
    int m_cnt = 0;
    int m_upd = 0;
    bit m_sqw = 0, m_p = 0, m_u = 0, m_uip = 0;

    always #4 clk = ~clk;

    rtcdiv_top dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .osc_ctl(osc_ctl),
        .rate_sel(rate_sel), .sqw_en(sqw_en), .freeze(freeze),
        .sqw(sqw), .periodic_stb(periodic_stb), .update_stb(update_stb), .uip(uip)
    );

    // R4: half-period in ticks derived from the selected frequency
    function automatic int half_ticks(input int code);
        int hz;
        if (code == 0) return 0;
        if (code == 1) hz = 256;
        else if (code == 2) hz = 128;
        else hz = 8192 >> (code - 3);
        return 16384 / hz;
    endfunction

    always @(posedge clk) begin
        int half;
        bit old_uip;
        cycle++;
        started = 1;
        half = half_ticks(int'(rate_sel));
        if (rst) begin
            m_cnt = 0; m_sqw = 0; m_p = 0; m_u = 0; m_uip = 0;
        end else if (osc_ctl != 3'b010) begin
            m_cnt = 0; m_sqw = 0; m_p = 0; m_u = 0; m_uip = 0;
        end else begin
            old_uip = m_uip;
            m_p = 0; m_u = 0;
            if (tick_en) begin
                m_cnt = (m_cnt + 1) % 32768;
                if (half > 0 && (m_cnt % (2 * half)) == half) m_p = 1;
                if (m_cnt == 16384 && old_uip && !freeze) begin
                    m_u = 1; m_upd++;
                end
            end
            if (freeze) m_uip = 0;
            else if (tick_en && m_cnt == 16376) m_uip = 1;
            else if (m_u) m_uip = 0;
            m_sqw = sqw_en && half > 0 && ((m_cnt / half) % 2 == 1);
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cycle);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            if (phase_tag != "") begin
                chk(phase_tag, "sqw", sqw, m_sqw);
                chk(phase_tag, "periodic_stb", periodic_stb, m_p);
                chk(phase_tag, "update_stb", update_stb, m_u);
                chk(phase_tag, "uip", uip, m_uip);
            end else begin
                chk(sqw_en ? "R4" : "R5", "sqw", sqw, m_sqw);
                chk("R3", "periodic_stb", periodic_stb, m_p);
                chk("R6", "update_stb", update_stb, m_u);
                chk("R7", "uip", uip, m_uip);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_cnt(input int target);
        @(negedge clk);
        while (m_cnt != target) @(negedge clk);
    endtask

    task automatic quiet_check(input string tag);
        chk(tag, "sqw quiet", sqw, 1'b0);
        chk(tag, "periodic quiet", periodic_stb, 1'b0);
        chk(tag, "update quiet", update_stb, 1'b0);
        chk(tag, "uip quiet", uip, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick_en = 1'b1;
        cycles(4);
        rst = 1'b0;
        @(negedge clk);
        quiet_check("R1");

        // R2: every non-running pattern, with ticks present
        phase_tag = "R2";
        sqw_en = 1'b1; rate_sel = 4'd3;
        foreach (osc_ctl_list[i]) begin
            osc_ctl = osc_ctl_list[i];
            cycles(20);
            quiet_check("R2");
        end
        phase_tag = "";

        // R3/R4/R5: sweep all rate codes from a fresh release
        osc_ctl = 3'b010;
        for (int code = 0; code < 16; code++) begin
            rate_sel = 4'(code);
            sqw_en = (code != 9);
            cycles(350);
            if (code == 12) sqw_en = 1'b0;
            cycles(350);
        end

        // R9: irregular enable
        phase_tag = "R9";
        rate_sel = 4'd4; sqw_en = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            tick_en = (($urandom % 4) != 0);
            @(negedge clk);
        end
        tick_en = 1'b1;
        phase_tag = "";

        // R6/R7: first update after release
        rate_sel = 4'd15;
        while (m_upd < 1) @(negedge clk);

        // R8: freeze held across the second update point
        wait_cnt(16300);
        phase_tag = "R8";
        freeze = 1'b1;
        wait_cnt(16500);
        freeze = 1'b0;
        phase_tag = "";

        // R8: freeze pulse inside the warning window
        wait_cnt(16379);
        phase_tag = "R8";
        chk("R8", "uip in window", uip, 1'b1);
        freeze = 1'b1;
        @(negedge clk);
        freeze = 1'b0;
        chk("R8", "uip after freeze", uip, 1'b0);
        wait_cnt(16400);
        phase_tag = "";
        chk("R8", "updates suppressed", logic'(m_upd == 1), 1'b1);

        // R6/R7: a normal update afterwards
        while (m_upd < 2) @(negedge clk);

        // R2: stop mid-run, restart from zero
        phase_tag = "R2";
        osc_ctl = 3'b000;
        cycles(10);
        quiet_check("R2");
        osc_ctl = 3'b110;
        cycles(10);
        phase_tag = "";
        osc_ctl = 3'b010;
        rate_sel = 4'd1;
        while (m_upd < 3) @(negedge clk);
        cycles(50);

        // R1: reset mid-run
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        quiet_check("R1");
        cycles(5);
        finish_run();
    end

    logic [2:0] osc_ctl_list [5] = '{3'b000, 3'b110, 3'b111, 3'b001, 3'b011};

endmodule